// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel

This block produces one pulse-width-modulated output from a fractional phase accumulator. Every clock it adds a phase step to a 42-bit fraction, so the carrier period in cycles is the reciprocal of that step. The carrier can be a sawtooth (asymmetric PWM) or a triangle folded from the same phase (symmetric PWM, with the active phase centred on the period start). The channel compares the carrier against a duty ratio. It delays each rising edge of the main and complementary legs by a programmable dead time, picks one leg, and then applies the output polarity.

A one-cycle sync pulse places the accumulator at a programmable initial phase. On the same pulse the channel captures its polarity, enable, carrier mode and dead time. These settings then hold until the next sync. The duty ratio is taken at every carrier wrap and at every sync. In triangle mode it is also taken at mid-period. Between syncs the carrier runs freely. An enable that stays on for one period gives one-shot operation. A live force-off input drives the output to its inactive level at once.

Top module: `pwmc_channel`

## Requirements
- R1: Each clock the phase fraction grows by `phase_inc` modulo one, so the carrier period is 2^42 / `phase_inc` cycles (for example, a step of 2^35 gives 128 cycles).
- R2: In sawtooth mode (`mode_in`=0) the carrier is the top 10 bits of the phase, and the raw active phase holds while `duty` (11 bits, 1024 = 1.0) is strictly greater than the carrier.
- R3: In triangle mode (`mode_in`=1) the carrier is twice the phase for the first half-period (phase bits 40..31) and the bitwise inverse of those bits for the second half. The active phase is the same strict comparison as in R2.
- R4: A duty of 0 gives an output that never becomes active, and a duty of 1024 gives an output that is active on every cycle.
- R5: The duty value in use is reloaded from `duty` only on a sync, on a carrier wrap, or (triangle mode only) on the crossing into the second half-period. A change at any other time has no effect until then.
- R6: A sync loads `init_phase` into the 10 most significant bits of the phase and clears the rest.
- R7: A sync captures `pol_in`, `en_in`, `mode_in` and `dt_in`. Changes on those inputs between syncs have no effect.
- R8: Each rising edge of the main leg (raw active) and of the complementary leg (raw inactive) is delayed by the captured dead time in clock cycles. Falling edges are not delayed, so the two legs are never active together.
- R9: With `comp_sel` high the output follows the complementary leg. With it low the output follows the main leg.
- R10: With captured polarity 1 an active leg drives `pwm_out` high. With polarity 0 the level is inverted.
- R11: When the captured enable is 0 or `force_off` is high, `pwm_out` sits at the inactive level (the inverse of the captured polarity) in the same cycle.
- R12: Reset leaves the phase at zero, polarity at 1, enable at 0, dead time at 0 and duty at 0, so `pwm_out` is low until a sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_inc | input | 42 | Phase step per clock, unsigned pure fraction |
| duty | input | 11 | Duty ratio, 10 fractional bits, 0..1024 |
| init_phase | input | 10 | Phase loaded on sync, fraction of a period |
| pol_in | input | 1 | Output polarity, 1 = active-high |
| mode_in | input | 1 | Carrier shape, 0 = sawtooth, 1 = triangle |
| dt_in | input | 10 | Dead time in clock cycles |
| en_in | input | 1 | Channel on/off |
| comp_sel | input | 1 | Select the complementary leg |
| sync | input | 1 | Restart phase and capture configuration |
| force_off | input | 1 | Immediate force to inactive level |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is a duty change that arrives inside a carrier period. That change must stay invisible until the wrap, or until mid-period in triangle mode. A free-running carrier hides which update point was used. The bench therefore issues a sync at phase zero, changes the duty from 0 to full scale ten cycles later, and samples the output on both sides of the expected update point. It runs this once for each carrier shape. Dead time is checked with a 64-cycle period, where every high and low run has a known length and the high count in one period gives the delay directly.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    typedef enum logic {
        MODE_SAW = 1'b0,
        MODE_TRI = 1'b1
    } carrier_mode_e;

    typedef struct packed {
        logic          pol;
        logic          en;
        carrier_mode_e mode;
    } chan_cfg_t;

    typedef struct packed {
        logic wrap;
        logic mid;
    } carrier_evt_t;

    function automatic logic drive_level(input logic pol, input logic act);
        return pol ? act : !act;
    endfunction

endpackage

// File: rtl/pwmc_carrier.sv
module pwmc_carrier
    import pwmc_pkg::*;
#(
    parameter int PH_W   = 42,
    parameter int CMP_W  = 10,
    parameter int INIT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase_inc,
    input  logic [INIT_W-1:0] init_phase,
    input  logic              sync,
    input  carrier_mode_e     mode,
    output logic [CMP_W-1:0]  carrier,
    output carrier_evt_t      evt
);
    localparam int PAD_W = PH_W - INIT_W;

    logic [PH_W-1:0]  phase_q;
    logic [PH_W:0]    sum;
    logic [CMP_W-1:0] half_bits;

    assign sum = {1'b0, phase_q} + {1'b0, phase_inc};

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (sync)
            phase_q <= {init_phase, {PAD_W{1'b0}}};
        else
            phase_q <= sum[PH_W-1:0];
    end

    always_comb begin
        evt.wrap = !sync && sum[PH_W];
        evt.mid  = !sync && (mode == MODE_TRI) && !phase_q[PH_W-1]
                   && sum[PH_W-1] && !sum[PH_W];
    end

    assign half_bits = phase_q[PH_W-2 -: CMP_W];

    generate
        if (PH_W > CMP_W) begin : g_shape
            always_comb begin
                if (mode == MODE_TRI)
                    carrier = phase_q[PH_W-1] ? ~half_bits : half_bits;
                else
                    carrier = phase_q[PH_W-1 -: CMP_W];
            end
        end else begin : g_narrow
            always_comb carrier = phase_q[PH_W-1 -: CMP_W];
        end
    endgenerate

endmodule

// File: rtl/pwmc_deadband.sv
module pwmc_deadband #(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw,
    input  logic [DT_W-1:0] dt,
    output logic            main_q,
    output logic            comp_q
);
    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    logic            raw_q;
    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] cnt_d;
    logic            settled;

    always_comb begin
        if (raw != raw_q)
            cnt_d = dt;
        else if (cnt_q != '0)
            cnt_d = cnt_q - ONE;
        else
            cnt_d = cnt_q;
    end

    assign settled = (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= 1'b0;
            cnt_q  <= '0;
            main_q <= 1'b0;
            comp_q <= 1'b0;
        end else begin
            raw_q  <= raw;
            cnt_q  <= cnt_d;
            main_q <= raw && settled;
            comp_q <= !raw && settled;
        end
    end

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel
    import pwmc_pkg::*;
#(
    parameter int PH_W   = 42,
    parameter int DUTY_W = 10,
    parameter int INIT_W = 10,
    parameter int DT_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   phase_inc,
    input  logic [DUTY_W:0]   duty,
    input  logic [INIT_W-1:0] init_phase,
    input  logic              pol_in,
    input  logic              mode_in,
    input  logic [DT_W-1:0]   dt_in,
    input  logic              en_in,
    input  logic              comp_sel,
    input  logic              sync,
    input  logic              force_off,
    output logic              pwm_out
);
    localparam int CMP_W = DUTY_W;

    chan_cfg_t        cfg_q;
    logic [DT_W-1:0]  dt_q;
    logic [DUTY_W:0]  duty_q;
    logic [CMP_W-1:0] carrier;
    carrier_evt_t     evt;
    logic             reload;
    logic             raw_act;
    logic             main_q;
    logic             comp_q;
    logic             leg;
    logic             act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{pol: 1'b1, en: 1'b0, mode: MODE_SAW};
            dt_q  <= '0;
        end else if (sync) begin
            cfg_q <= '{pol: pol_in, en: en_in, mode: carrier_mode_e'(mode_in)};
            dt_q  <= dt_in;
        end
    end

    pwmc_carrier #(
        .PH_W   (PH_W),
        .CMP_W  (CMP_W),
        .INIT_W (INIT_W)
    ) i_carrier (
        .clk        (clk),
        .rst        (rst),
        .phase_inc  (phase_inc),
        .init_phase (init_phase),
        .sync       (sync),
        .mode       (cfg_q.mode),
        .carrier    (carrier),
        .evt        (evt)
    );

    assign reload = sync || evt.wrap || evt.mid;

    always_ff @(posedge clk) begin
        if (rst)
            duty_q <= '0;
        else if (reload)
            duty_q <= duty;
    end

    assign raw_act = ({1'b0, carrier} < duty_q);

    pwmc_deadband #(
        .DT_W (DT_W)
    ) i_deadband (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_act),
        .dt     (dt_q),
        .main_q (main_q),
        .comp_q (comp_q)
    );

    assign leg     = comp_sel ? comp_q : main_q;
    assign act     = leg && cfg_q.en && !force_off;
    assign pwm_out = drive_level(cfg_q.pol, act);

endmodule

// File: rtl/pwmc_channel_chk.sv
module pwmc_channel_chk #(
    parameter int DUTY_W = 10,
    parameter int DT_W   = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            sync,
    input logic            force_off,
    input logic            pol_in,
    input logic            en_in,
    input logic [DUTY_W:0] duty,
    input logic            pol_q,
    input logic            en_q,
    input logic [DUTY_W:0] duty_q,
    input logic            wrap,
    input logic            mid,
    input logic            main_q,
    input logic            comp_q,
    input logic [DT_W-1:0] dt_q,
    input logic            pwm_out
);

    AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!en_q || force_off) |-> (pwm_out == !pol_q)); // R11

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sync |=> ($stable(pol_q) && $stable(en_q))); // R7

    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        sync |=> (pol_q == $past(pol_in) && en_q == $past(en_in))); // R7

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(sync || wrap || mid) |=> $stable(duty_q)); // R5

    AST_DUTY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sync || wrap || mid) |=> (duty_q == $past(duty))); // R5

    AST_LEGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(main_q && comp_q)); // R8

    AST_DT_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(main_q) && dt_q != '0) |-> !$past(comp_q)); // R8

endmodule

bind pwmc_channel pwmc_channel_chk #(
    .DUTY_W (DUTY_W),
    .DT_W   (DT_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .sync      (sync),
    .force_off (force_off),
    .pol_in    (pol_in),
    .en_in     (en_in),
    .duty      (duty),
    .pol_q     (cfg_q.pol),
    .en_q      (cfg_q.en),
    .duty_q    (duty_q),
    .wrap      (evt.wrap),
    .mid       (evt.mid),
    .main_q    (main_q),
    .comp_q    (comp_q),
    .dt_q      (dt_q),
    .pwm_out   (pwm_out)
);

// File: tb/test_pwmc_channel.sv
module test_pwmc_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [41:0] phase_inc;
    logic [10:0] duty;
    logic [9:0]  init_phase;
    logic        pol_in, mode_in, en_in, comp_sel, sync, force_off;
    logic [9:0]  dt_in;
    logic        pwm_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pwmc_channel i_pwmc_channel (
        .clk        (clk),
        .rst        (rst),
        .phase_inc  (phase_inc),
        .duty       (duty),
        .init_phase (init_phase),
        .pol_in     (pol_in),
        .mode_in    (mode_in),
        .dt_in      (dt_in),
        .en_in      (en_in),
        .comp_sel   (comp_sel),
        .sync       (sync),
        .force_off  (force_off),
        .pwm_out    (pwm_out)
    );

    typedef struct packed {
        logic        mode;
        logic        pol;
        logic        en;
        logic        fo;
        logic        comp;
        logic [9:0]  dt;
        logic [10:0] dty;
        logic [7:0]  exp_hi;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd0,    8'd0,  4'd4},  // R4 zero duty
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd100,  8'd7,  4'd2},  // R2
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd512,  8'd32, 4'd2},  // R2
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd1000, 8'd63, 4'd2},  // R2
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd1024, 8'd64, 4'd4},  // R4 full duty
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd100,  8'd7,  4'd3},  // R3
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd512,  8'd32, 4'd3},  // R3
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 11'd1024, 8'd64, 4'd4},  // R4
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 11'd512,  8'd27, 4'd8},  // R8 main leg
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10'd5, 11'd512,  8'd27, 4'd9},  // R9 comp leg with dead time
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 10'd3, 11'd512,  8'd29, 4'd8},  // R8 triangle comp
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd2, 11'd100,  8'd5,  4'd8},  // R8 wrapped run
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0, 11'd100,  8'd57, 4'd10}, // R10 active-low
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd0, 11'd512,  8'd0,  4'd11}, // R11 disabled
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd0, 11'd512,  8'd64, 4'd11}, // R11 forced off, active-low
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 10'd0, 11'd100,  8'd57, 4'd9}   // R9 comp leg
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_sync();
        @(negedge clk) sync = 1'b1;
        @(negedge clk) sync = 1'b0;
    endtask

    task automatic count_high(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out) c++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c;
        phase_inc  = 42'h1 << 36;
        duty       = 11'd1024;
        init_phase = '0;
        pol_in     = 1'b0;
        mode_in    = 1'b0;
        dt_in      = '0;
        en_in      = 1'b1;
        comp_sel   = 1'b0;
        sync       = 1'b0;
        force_off  = 1'b0;

        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12 output low in reset", int'(pwm_out), 0);
        rst = 1'b0;
        count_high(100, c);
        check("R12 output low after reset without sync", c, 0);

        // table of configurations, 64-cycle period
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            mode_in   = VEC[i].mode;
            pol_in    = VEC[i].pol;
            en_in     = VEC[i].en;
            force_off = VEC[i].fo;
            comp_sel  = VEC[i].comp;
            dt_in     = VEC[i].dt;
            duty      = VEC[i].dty;
            pulse_sync();
            repeat (200) @(negedge clk);
            count_high(64, c);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), c, int'(VEC[i].exp_hi));
        end
        force_off = 1'b0;
        comp_sel  = 1'b0;

        // R7: configuration inputs ignored between syncs
        @(negedge clk);
        mode_in = 1'b0; pol_in = 1'b1; en_in = 1'b1; dt_in = '0; duty = 11'd100;
        pulse_sync();
        @(negedge clk);
        pol_in = 1'b0; mode_in = 1'b1; dt_in = 10'd7; en_in = 1'b0;
        repeat (200) @(negedge clk);
        count_high(64, c);
        check("R7 config held without sync", c, 7);

        // R1: period set by phase step (128 cycles)
        @(negedge clk);
        phase_inc = 42'h1 << 35;
        pol_in = 1'b1; mode_in = 1'b0; en_in = 1'b1; dt_in = '0; duty = 11'd512;
        pulse_sync();
        repeat (300) @(negedge clk);
        count_high(128, c);
        check("R1 half duty over 128-cycle period", c, 64);
        phase_inc = 42'h1 << 36;

        // R5: sawtooth duty change takes effect only at wrap
        duty = 11'd0;
        pulse_sync();
        repeat (10) @(negedge clk);
        duty = 11'd1024;
        repeat (30) @(negedge clk);
        check("R5 saw duty held before wrap", int'(pwm_out), 0);
        repeat (30) @(negedge clk);
        check("R5 saw duty taken after wrap", int'(pwm_out), 1);

        // R5: triangle duty change takes effect at mid-period
        mode_in = 1'b1;
        duty = 11'd0;
        pulse_sync();
        repeat (10) @(negedge clk);
        duty = 11'd1024;
        repeat (10) @(negedge clk);
        check("R5 tri duty held before mid-period", int'(pwm_out), 0);
        repeat (20) @(negedge clk);
        check("R5 tri duty taken at mid-period", int'(pwm_out), 1);

        // R6: initial phase of one half
        mode_in = 1'b0;
        duty = 11'd512;
        init_phase = 10'd512;
        pulse_sync();
        repeat (5) @(negedge clk);
        check("R6 inactive in second half after sync", int'(pwm_out), 0);
        repeat (15) @(negedge clk);
        check("R6 still inactive before wrap", int'(pwm_out), 0);
        repeat (20) @(negedge clk);
        check("R6 active after wrap", int'(pwm_out), 1);

        // R11: force_off acts in the same cycle
        @(negedge clk);
        force_off = 1'b1;
        #1;
        check("R11 force_off immediate", int'(pwm_out), 0);
        force_off = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule